// File: doc/BRIEF.md
# SIMT Divergence Mask Controller

This block keeps the program counter and the active-lane mask of one warp, a group of lanes that all run from a single shared program counter. At launch it loads a start PC and a lane count, and it switches off for good every lane at or above that count. This covers a partial last warp. For example, 20 threads in warps of 8 lanes leave the third warp with 4 live lanes.

On a conditional branch the execution side hands over one predicate bit per lane, together with the taken target, the fall-through PC and the reconvergence PC. If every active lane agrees, only the PC moves. If the lanes disagree, the controller pushes a divergence entry and runs the taken path with only the taking lanes. When execution reports that it reached the reconvergence PC, the controller switches to the fall-through path with the remaining lanes. When the reconvergence PC is reached a second time, it restores the pre-branch mask. Entries nest up to a parameterised depth. A divergent branch that finds the stack full is dropped and raises a sticky error. An issue counter lets a bench measure what serialisation costs.

Top module: `simt_mask_ctrl`

## Requirements
- R1: After reset, cur_pc is 0, act_mask is 0, ovf_err is 0 and issue_cnt is 0.
- R2: A launch sets cur_pc to launch_pc and sets act_mask bit i (bit 0 = lane 0) exactly when i < launch_lanes. It empties the divergence stack and clears issue_cnt to 0.
- R3: On a branch where the predicate is 1 for every active lane, cur_pc becomes br_target. Where it is 0 for every active lane, cur_pc becomes br_fall. In both cases the mask is unchanged, and predicate bits of inactive lanes have no effect.
- R4: On a branch where active lanes disagree and the stack is not full, cur_pc becomes br_target and act_mask becomes br_pred AND the old mask.
- R5: When adv reports the top entry's reconvergence PC during the taken pass, cur_pc becomes the stored fall-through PC and act_mask becomes the old mask AND NOT br_pred.
- R6: When adv reports the top entry's reconvergence PC during the second pass, cur_pc becomes that PC, act_mask returns to the pre-branch mask and the entry is popped.
- R7: An adv whose PC does not match the top reconvergence PC, or an adv with an empty stack, sets cur_pc to adv_pc and leaves act_mask unchanged.
- R8: Divergent branches nest up to DEPTH entries, and they unwind innermost first.
- R9: A divergent branch with DEPTH entries already held leaves cur_pc and act_mask unchanged and sets ovf_err. ovf_err stays at 1 until reset, including across launches.
- R10: issue_cnt rises by 1 for each accepted branch or advance. An even/odd split over a body of B instructions per path costs 2B+3 issues, where a uniform branch costs B+2.
- R11: In one cycle, launch takes priority over a branch and a branch takes priority over an advance. The lower-priority event is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| launch | input | 1 | Start the warp |
| launch_pc | input | PC_W | Start PC |
| launch_lanes | input | clog2(LANES+1) | Live thread count in this warp |
| br_valid | input | 1 | Branch event |
| br_pred | input | LANES | Per-lane branch predicate |
| br_target | input | PC_W | Taken target PC |
| br_fall | input | PC_W | Fall-through PC |
| br_reconv | input | PC_W | Reconvergence PC |
| adv | input | 1 | Execution reached adv_pc |
| adv_pc | input | PC_W | PC reached by execution |
| cur_pc | output | PC_W | Current warp PC |
| act_mask | output | LANES | Current active-lane mask |
| ovf_err | output | 1 | Sticky divergence stack overflow |
| issue_cnt | output | ISS_W | Issued events since launch |

## Verification
Two pairs of events can land in the same cycle: a launch together with a branch, and a branch together with a reconvergence advance. The bench drives both pairs on one edge. It judges the result from cur_pc, act_mask and issue_cnt, which must show only the higher-priority event. All 256 predicate patterns of an 8-lane warp are swept with a full mask and with a 5-lane tail mask. Each expected mask and PC is computed from the AND of predicate and mask.

// File: rtl/simt_div_pkg.sv
package simt_div_pkg;
  typedef enum logic [1:0] {
    BK_FALL  = 2'd0,
    BK_TAKE  = 2'd1,
    BK_SPLIT = 2'd2
  } br_kind_e;
endpackage

// File: rtl/lane_tail_mask.sv
module lane_tail_mask #(
  parameter int LANES = 32,
  localparam int LC_W = $clog2(LANES + 1)
) (
  input  logic [LC_W-1:0]  count,
  output logic [LANES-1:0] mask
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign mask[i] = (count > LC_W'(i));
  end
endmodule

// File: rtl/br_classify.sv
module br_classify
  import simt_div_pkg::*;
#(
  parameter int LANES = 32
) (
  input  logic [LANES-1:0] pred,
  input  logic [LANES-1:0] mask,
  output br_kind_e         kind,
  output logic [LANES-1:0] take_mask,
  output logic [LANES-1:0] rest_mask
);
  always_comb begin
    take_mask = pred & mask;
    rest_mask = ~pred & mask;
    if (take_mask == '0)      kind = BK_FALL;
    else if (rest_mask == '0) kind = BK_TAKE;
    else                      kind = BK_SPLIT;
  end
endmodule

// File: rtl/div_stack.sv
module div_stack #(
  parameter int W     = 8,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int SW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic          upd,
  input  logic          pop,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  top_data,
  output logic [SW-1:0] depth,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] top_idx;
  logic [AW-1:0] waddr;

  assign top_idx  = AW'(depth - 1'b1);
  assign waddr    = push ? AW'(depth) : top_idx;
  assign top_data = mem[top_idx];
  assign full     = (depth == SW'(DEPTH));
  assign empty    = (depth == '0);

  always_ff @(posedge clk) begin
    if (push || upd) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || clr)    depth <= '0;
    else if (push)     depth <= depth + 1'b1;
    else if (pop)      depth <= depth - 1'b1;
  end
endmodule

// File: rtl/simt_mask_ctrl.sv
module simt_mask_ctrl
  import simt_div_pkg::*;
#(
  parameter int LANES = 32,
  parameter int PC_W  = 16,
  parameter int DEPTH = 8,
  parameter int ISS_W = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       launch,
  input  logic [PC_W-1:0]            launch_pc,
  input  logic [$clog2(LANES+1)-1:0] launch_lanes,
  input  logic                       br_valid,
  input  logic [LANES-1:0]           br_pred,
  input  logic [PC_W-1:0]            br_target,
  input  logic [PC_W-1:0]            br_fall,
  input  logic [PC_W-1:0]            br_reconv,
  input  logic                       adv,
  input  logic [PC_W-1:0]            adv_pc,
  output logic [PC_W-1:0]            cur_pc,
  output logic [LANES-1:0]           act_mask,
  output logic                       ovf_err,
  output logic [ISS_W-1:0]           issue_cnt
);
  localparam int SW = $clog2(DEPTH + 1);

  typedef struct packed {
    logic [PC_W-1:0]  rcv;
    logic [PC_W-1:0]  alt_pc;
    logic [LANES-1:0] alt_mask;
    logic [LANES-1:0] home_mask;
    logic             second;
  } ent_t;
  localparam int EW = $bits(ent_t);

  logic [LANES-1:0] tail_mask, take_mask, rest_mask;
  br_kind_e         kind;
  ent_t             top_ent, wr_ent;
  logic [EW-1:0]    top_raw;
  logic [SW-1:0]    stk_depth;
  logic             stk_full, stk_empty;
  logic             do_br, do_adv, hit, push, upd, pop;

  lane_tail_mask #(.LANES(LANES)) u_tail (
    .count(launch_lanes), .mask(tail_mask)
  );

  br_classify #(.LANES(LANES)) u_cls (
    .pred(br_pred), .mask(act_mask), .kind(kind),
    .take_mask(take_mask), .rest_mask(rest_mask)
  );

  assign top_ent = ent_t'(top_raw);
  assign do_br   = !launch && br_valid;
  assign do_adv  = !launch && !br_valid && adv;
  assign hit     = !stk_empty && (adv_pc == top_ent.rcv);
  assign push    = do_br && (kind == BK_SPLIT) && !stk_full;
  assign upd     = do_adv && hit && !top_ent.second;
  assign pop     = do_adv && hit && top_ent.second;

  always_comb begin
    if (push) begin
      wr_ent.rcv       = br_reconv;
      wr_ent.alt_pc    = br_fall;
      wr_ent.alt_mask  = rest_mask;
      wr_ent.home_mask = act_mask;
      wr_ent.second    = 1'b0;
    end else begin
      wr_ent        = top_ent;
      wr_ent.second = 1'b1;
    end
  end

  div_stack #(.W(EW), .DEPTH(DEPTH)) u_stk (
    .clk(clk), .rst(rst), .clr(launch),
    .push(push), .upd(upd), .pop(pop),
    .wdata(wr_ent), .top_data(top_raw),
    .depth(stk_depth), .full(stk_full), .empty(stk_empty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_pc    <= '0;
      act_mask  <= '0;
      ovf_err   <= 1'b0;
      issue_cnt <= '0;
    end else if (launch) begin
      cur_pc    <= launch_pc;
      act_mask  <= tail_mask;
      issue_cnt <= '0;
    end else if (do_br) begin
      issue_cnt <= issue_cnt + 1'b1;
      case (kind)
        BK_FALL: cur_pc <= br_fall;
        BK_TAKE: cur_pc <= br_target;
        default: begin
          if (stk_full) begin
            ovf_err <= 1'b1;
          end else begin
            cur_pc   <= br_target;
            act_mask <= take_mask;
          end
        end
      endcase
    end else if (do_adv) begin
      issue_cnt <= issue_cnt + 1'b1;
      if (upd) begin
        cur_pc   <= top_ent.alt_pc;
        act_mask <= top_ent.alt_mask;
      end else if (pop) begin
        cur_pc   <= adv_pc;
        act_mask <= top_ent.home_mask;
      end else begin
        cur_pc   <= adv_pc;
      end
    end
  end
endmodule

// File: rtl/simt_mask_chk.sv
module simt_mask_chk #(
  parameter int LANES = 32,
  parameter int PC_W  = 16,
  parameter int DEPTH = 8,
  parameter int ISS_W = 16
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       launch,
  input logic [$clog2(LANES+1)-1:0] launch_lanes,
  input logic                       br_valid,
  input logic [LANES-1:0]           br_pred,
  input logic [PC_W-1:0]            br_target,
  input logic                       adv,
  input logic [PC_W-1:0]            adv_pc,
  input logic [PC_W-1:0]            cur_pc,
  input logic [LANES-1:0]           act_mask,
  input logic                       ovf_err,
  input logic [ISS_W-1:0]           issue_cnt,
  input logic [$clog2(DEPTH+1)-1:0] depth
);
  localparam int SW = $clog2(DEPTH + 1);

  AST_LAUNCH_LANES: assert property (@(posedge clk) disable iff (rst)
    launch && (launch_lanes <= LANES) |=> ($countones(act_mask) == 32'($past(launch_lanes))) && (issue_cnt == '0)); // R2

  AST_UNIFORM_TAKE: assert property (@(posedge clk) disable iff (rst)
    !launch && br_valid && (act_mask != '0) && ((br_pred & act_mask) == act_mask)
    |=> (act_mask == $past(act_mask)) && (cur_pc == $past(br_target))); // R3

  AST_SPLIT_MASK: assert property (@(posedge clk) disable iff (rst)
    !launch && br_valid && ((br_pred & act_mask) != '0) && ((~br_pred & act_mask) != '0) && (depth != SW'(DEPTH))
    |=> act_mask == ($past(br_pred) & $past(act_mask))); // R4

  AST_PLAIN_ADV: assert property (@(posedge clk) disable iff (rst)
    !launch && !br_valid && adv && (depth == '0)
    |=> (cur_pc == $past(adv_pc)) && (act_mask == $past(act_mask))); // R7

  AST_NO_OVERFLOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    !launch && br_valid && ((br_pred & act_mask) != '0) && ((~br_pred & act_mask) != '0) && (depth == SW'(DEPTH))
    |=> ovf_err && $stable(act_mask) && $stable(cur_pc)); // R9

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(ovf_err) |-> ovf_err); // R9

  AST_ISSUE_STEP: assert property (@(posedge clk) disable iff (rst)
    !launch && (br_valid || adv) |=> issue_cnt == ISS_W'($past(issue_cnt) + 1'b1)); // R10
endmodule

bind simt_mask_ctrl simt_mask_chk #(
  .LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH), .ISS_W(ISS_W)
) u_chk (
  .clk(clk), .rst(rst), .launch(launch), .launch_lanes(launch_lanes),
  .br_valid(br_valid), .br_pred(br_pred), .br_target(br_target),
  .adv(adv), .adv_pc(adv_pc), .cur_pc(cur_pc), .act_mask(act_mask),
  .ovf_err(ovf_err), .issue_cnt(issue_cnt), .depth(stk_depth)
);

// File: tb/tb_simt_mask_ctrl.sv
`timescale 1ns/1ps
module tb_simt_mask_ctrl;
  localparam int LANES = 8;
  localparam int PC_W  = 16;
  localparam int DEPTH = 4;
  localparam int ISS_W = 16;
  localparam int LC_W  = $clog2(LANES + 1);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             launch = 1'b0;
  logic [PC_W-1:0]  launch_pc = '0;
  logic [LC_W-1:0]  launch_lanes = '0;
  logic             br_valid = 1'b0;
  logic [LANES-1:0] br_pred = '0;
  logic [PC_W-1:0]  br_target = '0, br_fall = '0, br_reconv = '0;
  logic             adv = 1'b0;
  logic [PC_W-1:0]  adv_pc = '0;
  logic [PC_W-1:0]  cur_pc;
  logic [LANES-1:0] act_mask;
  logic             ovf_err;
  logic [ISS_W-1:0] issue_cnt;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  simt_mask_ctrl #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH), .ISS_W(ISS_W)) dut (
    .clk(clk), .rst(rst), .launch(launch), .launch_pc(launch_pc),
    .launch_lanes(launch_lanes), .br_valid(br_valid), .br_pred(br_pred),
    .br_target(br_target), .br_fall(br_fall), .br_reconv(br_reconv),
    .adv(adv), .adv_pc(adv_pc), .cur_pc(cur_pc), .act_mask(act_mask),
    .ovf_err(ovf_err), .issue_cnt(issue_cnt)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    launch = 1'b0; br_valid = 1'b0; adv = 1'b0;
  endtask

  task automatic set_launch(input logic [PC_W-1:0] pc, input int lanes);
    launch = 1'b1; launch_pc = pc; launch_lanes = LC_W'(lanes);
  endtask

  task automatic set_br(input logic [LANES-1:0] p, input logic [PC_W-1:0] t,
                        input logic [PC_W-1:0] f, input logic [PC_W-1:0] r);
    br_valid = 1'b1; br_pred = p; br_target = t; br_fall = f; br_reconv = r;
  endtask

  task automatic set_adv(input logic [PC_W-1:0] pc);
    adv = 1'b1; adv_pc = pc;
  endtask

  task automatic body(input int base, input int n);
    for (int k = 0; k < n; k++) begin
      set_adv(PC_W'(base + k)); step();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [LANES-1:0] m, t, nt;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 pc", 32'(cur_pc), 0);
    chk("R1 mask", 32'(act_mask), 0);
    chk("R1 err", 32'(ovf_err), 0);
    chk("R1 cnt", 32'(issue_cnt), 0);

    // R2: every lane count, including 20 threads -> third warp has 4 lanes
    for (int n = 0; n <= LANES; n++) begin
      set_launch(PC_W'(16'h0040 + n), n); step();
      chk("R2 pc", 32'(cur_pc), 32'(16'h0040 + n));
      chk("R2 mask", 32'(act_mask), (32'd1 << n) - 1);
      chk("R2 cnt", 32'(issue_cnt), 0);
    end
    set_launch(16'h0050, 20 - 2 * LANES); step();
    chk("R2 tail of 20 threads", 32'(act_mask), 32'h0F);

    // R3..R7, R10: sweep every predicate on a full and a tail mask
    for (int ln = 5; ln <= LANES; ln += 3) begin
      m = LANES'((32'd1 << ln) - 1);
      for (int p = 0; p < (1 << LANES); p++) begin
        set_launch(16'h0100, ln); step();
        set_br(LANES'(p), 16'h0200, 16'h0300, 16'h0400); step();
        t  = LANES'(p) & m;
        nt = ~LANES'(p) & m;
        if (t == '0) begin
          chk("R3 fall pc", 32'(cur_pc), 32'h0300);
          chk("R3 fall mask", 32'(act_mask), 32'(m));
        end else if (nt == '0) begin
          chk("R3 take pc", 32'(cur_pc), 32'h0200);
          chk("R3 take mask", 32'(act_mask), 32'(m));
        end else begin
          chk("R4 pc", 32'(cur_pc), 32'h0200);
          chk("R4 mask", 32'(act_mask), 32'(t));
          set_adv(16'h0400); step();
          chk("R5 pc", 32'(cur_pc), 32'h0300);
          chk("R5 mask", 32'(act_mask), 32'(nt));
        end
        set_adv(16'h0400); step();
        chk("R6_R7 pc", 32'(cur_pc), 32'h0400);
        chk("R6_R7 mask", 32'(act_mask), 32'(m));
        chk("R10 cnt", 32'(issue_cnt), (t != '0 && nt != '0) ? 3 : 2);
      end
    end

    // R10: even/odd split with 3-instruction bodies vs uniform
    set_launch(16'h0100, LANES); step();
    set_br(8'h55, 16'h0010, 16'h0020, 16'h0030); step();
    chk("R10 even lanes", 32'(act_mask), 32'h55);
    body(16'h0010, 3);
    chk("R7 inside body", 32'(cur_pc), 32'h0012);
    set_adv(16'h0030); step();
    chk("R5 odd lanes", 32'(act_mask), 32'hAA);
    body(16'h0020, 3);
    set_adv(16'h0030); step();
    chk("R10 split cost", 32'(issue_cnt), 9);
    chk("R6 restore", 32'(act_mask), 32'hFF);
    set_launch(16'h0100, LANES); step();
    set_br(8'hFF, 16'h0010, 16'h0020, 16'h0030); step();
    body(16'h0010, 3);
    set_adv(16'h0030); step();
    chk("R10 uniform cost", 32'(issue_cnt), 5);

    // R11: launch beats branch; branch beats advance
    set_launch(16'h0100, LANES); step();
    set_br(8'h0F, 16'h0500, 16'h0600, 16'h0700); step();
    set_launch(16'h0900, 3);
    set_br(8'h01, 16'h0A00, 16'h0B00, 16'h0C00); step();
    chk("R11 launch pc", 32'(cur_pc), 32'h0900);
    chk("R11 launch mask", 32'(act_mask), 32'h07);
    chk("R11 launch cnt", 32'(issue_cnt), 0);
    set_adv(16'h0700); step();
    chk("R11 stack cleared", 32'(act_mask), 32'h07);
    set_br(8'h07, 16'h0D00, 16'h0E00, 16'h0F00);
    set_adv(16'h0123); step();
    chk("R11 branch pc", 32'(cur_pc), 32'h0D00);
    chk("R11 branch cnt", 32'(issue_cnt), 2);

    // R8, R9: nest DEPTH splits, overflow, unwind
    set_launch(16'h0100, LANES); step();
    for (int k = 0; k < DEPTH; k++) begin
      set_br(LANES'(8'hFF << (k + 1)), PC_W'(16'h1000 + k),
             PC_W'(16'h2000 + k), PC_W'(16'h3000 + k)); step();
      chk("R8 nest mask", 32'(act_mask), 32'(LANES'(8'hFF << (k + 1))));
    end
    chk("R9 no err yet", 32'(ovf_err), 0);
    set_br(8'hE0, 16'h1100, 16'h2100, 16'h3100); step();
    chk("R9 err", 32'(ovf_err), 1);
    chk("R9 pc held", 32'(cur_pc), 32'h1000 + DEPTH - 1);
    chk("R9 mask held", 32'(act_mask), 32'(LANES'(8'hFF << DEPTH)));
    for (int k = DEPTH - 1; k >= 0; k--) begin
      set_adv(PC_W'(16'h3000 + k)); step();
      chk("R8 alt pc", 32'(cur_pc), 32'h2000 + k);
      chk("R8 alt mask", 32'(act_mask), 32'd1 << k);
      set_adv(PC_W'(16'h3000 + k)); step();
      chk("R8 home mask", 32'(act_mask), 32'(LANES'(8'hFF << k)));
    end
    set_launch(16'h0100, LANES); step();
    chk("R9 sticky", 32'(ovf_err), 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule